// File: doc/BRIEF.md
# Type-C CC Orientation and Debug Decoder

This block turns the digitally classified termination on each of the two configuration channel (CC) lines of a Type-C port into connection results: a two-bit orientation field, a single orientation pin level, a flag for a debug test system, and a control for the ID pin. The port role is already resolved elsewhere (Source or Sink). A role input tells the block which termination to look for. As a Sink it looks for a pull-up (Rp) advertised by the far end. As a Source it looks for a pull-down (Rd) presented by the far end.

The line classifications come from an upstream analog and debounce stage, together with a valid strobe. The block samples its inputs only on a strobe and holds every output between strobes. When both lines carry the expected termination, a debug accessory is present. The orientation is then still resolved to one line: in the Sink role the line with the stronger Rp level wins, and in the Source role a tie-break input decides.

Top module: `cc_orient_decoder`

## Requirements
- R1: Line codes are 3 bits: 0 Open, 1 Ra, 2 Rd, 3 Rp default, 4 Rp 1.5 A, 5 Rp 3.0 A; codes 6 and 7 count as Open. A strobe in which neither line carries the termination the role looks for gives field 00, pin low, debug flag 0 and ID released. This clears any earlier debug result.
- R2: Sink role (role input 0) with Rp on exactly one line: Rp on CC1 gives field 01, and Rp on CC2 gives field 10.
- R3: Sink role with Rp on both lines sets the debug flag. The field is 01 if the CC1 level is higher than or equal to the CC2 level, and 10 if the CC2 level is higher.
- R4: Source role (role input 1) with Rd on exactly one line: Rd on CC1 gives 01, and Rd on CC2 gives 10. Ra on the other line is treated like Open.
- R5: Source role with Rd on both lines sets the debug flag. The field is 10 when the tie-break input is 1, and 01 when it is 0.
- R6: The ID control (1 = drive ID low, 0 = high impedance) is 1 only after a strobe that detected a debug test system in the Source role. A Sink-role debug detection leaves ID released.
- R7: The orientation pin is high exactly when the field is 10.
- R8: Outputs change only on a clock edge with the valid strobe high. Without the strobe they hold their values.
- R9: After a synchronous active-low reset, the field is 00, the pin is low, the debug flag is 0 and ID is released.
- R10: In the Sink role, Ra and Rd count as Open. In the Source role, Ra and every Rp code count as Open.
- R11: The field never takes the value 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_valid | input | 1 | Strobe: line codes, role and tie-break are sampled this cycle |
| role_src | input | 1 | Resolved port role: 1 Source, 0 Sink |
| cc1_code | input | 3 | Classified termination on CC1 |
| cc2_code | input | 3 | Classified termination on CC2 |
| src_pick_cc2 | input | 1 | Source-role debug tie-break: 1 favours CC2 |
| orient_field | output | 2 | Orientation: 00 none, 01 CC1, 10 CC2 |
| orient_pin | output | 1 | High when orientation is CC2 |
| dbg_attached | output | 1 | Debug test system detected |
| id_pull_low | output | 1 | 1 drives ID low, 0 leaves it high impedance |

## Verification
A single strobe can resolve orientation and detect a debug accessory in the same cycle. The tie-break, the level comparison and the ID control must then all agree with the role sampled at that strobe. The bench provokes this with strobes that put the expected termination on both lines. It steps through equal and unequal Rp levels, flips the tie-break, and changes the role between back-to-back strobes. A behavioural model predicts field, pin, debug flag and ID together after every edge. Random strobes interleaved with idle cycles also test that a debug result is cleared by a detach and held across idle cycles.

// File: rtl/cc_orient_pkg.sv
// Package: shared encodings for the CC orientation decoder.
// Assumes the upstream classifier emits the 3-bit codes listed here.
package cc_orient_pkg;
    localparam int LINE_W = 3;

    typedef enum logic [LINE_W-1:0] {
        LN_OPEN  = 3'd0,
        LN_RA    = 3'd1,
        LN_RD    = 3'd2,
        LN_RPDEF = 3'd3,
        LN_RP15  = 3'd4,
        LN_RP30  = 3'd5
    } line_code_e;

    typedef enum logic [1:0] {
        OR_NONE = 2'b00,
        OR_CC1  = 2'b01,
        OR_CC2  = 2'b10
    } orient_e;

    // One line after role-independent interpretation
    typedef struct packed {
        logic       has_rp;
        logic       has_rd;
        logic [1:0] rp_lvl;
    } line_info_t;
endpackage

// File: rtl/cc_term_detect.sv
// Module: cc_term_detect
// Interprets one classified CC line code into termination flags.
// Assumes codes outside the defined set mean Open.
module cc_term_detect
    import cc_orient_pkg::*;
(
    input  logic [LINE_W-1:0] code,
    output line_info_t        info
);
    // Classify the code into pull-up, pull-down and Rp strength
    always_comb begin
        info = '0;
        case (code)
            LN_RD:    info.has_rd = 1'b1;
            LN_RPDEF: begin info.has_rp = 1'b1; info.rp_lvl = 2'd0; end
            LN_RP15:  begin info.has_rp = 1'b1; info.rp_lvl = 2'd1; end
            LN_RP30:  begin info.has_rp = 1'b1; info.rp_lvl = 2'd2; end
            default:  info = '0;
        endcase
    end
endmodule

// File: rtl/cc_orient_resolve.sv
// Module: cc_orient_resolve
// Combinational decision of orientation, debug presence and ID drive
// from both line interpretations and the role. Assumes role is stable
// while the strobe is high.
module cc_orient_resolve
    import cc_orient_pkg::*;
(
    input  line_info_t ln1,
    input  line_info_t ln2,
    input  logic       role_src,
    input  logic       pick_cc2,
    output logic [1:0] field,
    output logic       dbg,
    output logic       id_low
);
    logic term1;
    logic term2;
    logic tie_cc2;

    // Select the termination that matters for the current role
    always_comb begin
        term1   = role_src ? ln1.has_rd : ln1.has_rp;
        term2   = role_src ? ln2.has_rd : ln2.has_rp;
        tie_cc2 = role_src ? pick_cc2 : (ln2.rp_lvl > ln1.rp_lvl);
    end

    // Map terminated lines to orientation and debug results
    always_comb begin
        dbg = term1 & term2;
        unique case ({term2, term1})
            2'b01:   field = OR_CC1;
            2'b10:   field = OR_CC2;
            2'b11:   field = tie_cc2 ? OR_CC2 : OR_CC1;
            default: field = OR_NONE;
        endcase
        id_low = dbg & role_src;
    end
endmodule

// File: rtl/cc_orient_decoder.sv
// Module: cc_orient_decoder (top)
// Samples CC line classifications on a valid strobe and registers the
// orientation field, orientation pin, debug flag and ID control.
// Assumes line codes are already debounced upstream.
module cc_orient_decoder
    import cc_orient_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_valid,
    input  logic              role_src,
    input  logic [LINE_W-1:0] cc1_code,
    input  logic [LINE_W-1:0] cc2_code,
    input  logic              src_pick_cc2,
    output logic [1:0]        orient_field,
    output logic              orient_pin,
    output logic              dbg_attached,
    output logic              id_pull_low
);
    localparam int NLINES = 2;

    logic [LINE_W-1:0] codes [NLINES];
    line_info_t        infos [NLINES];
    logic [1:0]        nxt_field;
    logic              nxt_dbg;
    logic              nxt_id;

    // Gather both line codes for the per-line detectors
    always_comb begin
        codes[0] = cc1_code;
        codes[1] = cc2_code;
    end

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        cc_term_detect u_det (
            .code (codes[g]),
            .info (infos[g])
        );
    end

    cc_orient_resolve u_res (
        .ln1      (infos[0]),
        .ln2      (infos[1]),
        .role_src (role_src),
        .pick_cc2 (src_pick_cc2),
        .field    (nxt_field),
        .dbg      (nxt_dbg),
        .id_low   (nxt_id)
    );

    // Output register, loaded only on the valid strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            orient_field <= OR_NONE;
            orient_pin   <= 1'b0;
            dbg_attached <= 1'b0;
            id_pull_low  <= 1'b0;
        end else if (line_valid) begin
            orient_field <= nxt_field;
            orient_pin   <= (nxt_field == OR_CC2);
            dbg_attached <= nxt_dbg;
            id_pull_low  <= nxt_id;
        end
    end

    AST_PIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        orient_pin |-> (orient_field == OR_CC2)); // R7
    AST_PIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !orient_pin |-> (orient_field != OR_CC2)); // R7
    AST_NO_FIELD_11: assert property (@(posedge clk) disable iff (!rst_n)
        orient_field != 2'b11); // R11
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !line_valid |=> $stable({orient_field, orient_pin, dbg_attached, id_pull_low})); // R8
    AST_ID_NEEDS_DBG: assert property (@(posedge clk) disable iff (!rst_n)
        id_pull_low |-> dbg_attached); // R6
    AST_DBG_ORIENTED: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_attached |-> (orient_field == OR_CC1 || orient_field == OR_CC2)); // R3
    AST_DETACH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (line_valid && cc1_code == LN_OPEN && cc2_code == LN_OPEN)
        |=> (orient_field == OR_NONE && !dbg_attached && !id_pull_low)); // R1
    AST_SINK_DBG: assert property (@(posedge clk) disable iff (!rst_n)
        (line_valid && !role_src && cc1_code >= LN_RPDEF && cc1_code <= LN_RP30
         && cc2_code >= LN_RPDEF && cc2_code <= LN_RP30)
        |=> (dbg_attached && !id_pull_low)); // R3
    AST_SRC_DBG: assert property (@(posedge clk) disable iff (!rst_n)
        (line_valid && role_src && cc1_code == LN_RD && cc2_code == LN_RD)
        |=> (dbg_attached && id_pull_low)); // R5
endmodule

// File: tb/tb_cc_orient_decoder.sv
// Bench: behavioural reference updated per clock, compared every cycle.
module tb_cc_orient_decoder;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       line_valid;
    logic       role_src;
    logic [2:0] cc1_code;
    logic [2:0] cc2_code;
    logic       src_pick_cc2;
    logic [1:0] orient_field;
    logic       orient_pin;
    logic       dbg_attached;
    logic       id_pull_low;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 0;

    // Reference state
    logic [1:0] m_field = 2'b00;
    logic       m_dbg = 1'b0;
    logic       m_id = 1'b0;
    string      m_tag = "R9";

    always #5 clk = ~clk;

    cc_orient_decoder dut (
        .clk(clk), .rst_n(rst_n), .line_valid(line_valid), .role_src(role_src),
        .cc1_code(cc1_code), .cc2_code(cc2_code), .src_pick_cc2(src_pick_cc2),
        .orient_field(orient_field), .orient_pin(orient_pin),
        .dbg_attached(dbg_attached), .id_pull_low(id_pull_low)
    );

    // Rp strength 1..3 for Rp codes, 0 otherwise
    function automatic int rp_strength(input logic [2:0] c);
        if (c == 3) return 1;
        if (c == 4) return 2;
        if (c == 5) return 3;
        return 0;
    endfunction

    // Update model from the requirements at a clock edge
    task automatic model_edge();
        int s1, s2;
        bit t1, t2;
        if (!rst_n) begin
            m_field = 2'b00; m_dbg = 0; m_id = 0; m_tag = "R9";
            return;
        end
        if (!line_valid) begin
            m_tag = "R8";
            return;
        end
        s1 = rp_strength(cc1_code);
        s2 = rp_strength(cc2_code);
        if (role_src) begin
            t1 = (cc1_code == 2);
            t2 = (cc2_code == 2);
        end else begin
            t1 = (s1 > 0);
            t2 = (s2 > 0);
        end
        m_dbg = 0; m_id = 0;
        if (!t1 && !t2) begin
            m_field = 2'b00; m_tag = "R1";
        end else if (t1 && !t2) begin
            m_field = 2'b01; m_tag = role_src ? "R4" : "R2";
        end else if (!t1 && t2) begin
            m_field = 2'b10; m_tag = role_src ? "R4" : "R2";
        end else if (role_src) begin
            m_dbg = 1; m_id = 1; m_tag = "R5";
            m_field = src_pick_cc2 ? 2'b10 : 2'b01;
        end else begin
            m_dbg = 1; m_tag = "R3";
            m_field = (s2 > s1) ? 2'b10 : 2'b01;
        end
    endtask

    task automatic check_one(input string tag, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got field=%b pin=%b dbg=%b id=%b, expected field=%b pin=%b dbg=%b id=%b",
                     tag, act[4:3], act[2], act[1], act[0], exp[4:3], exp[2], exp[1], exp[0]);
        end
    endtask

    // One cycle: drive, clock, update model, compare mid-cycle
    task automatic step(input bit v, input bit r, input logic [2:0] a,
                        input logic [2:0] b, input bit t);
        logic [4:0] exp;
        line_valid = v; role_src = r; cc1_code = a; cc2_code = b; src_pick_cc2 = t;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        exp = {m_field, (m_field == 2'b10), m_dbg, m_id};  // R7 pin rule
        check_one(m_tag, {orient_field, orient_pin, dbg_attached, id_pull_low}, exp);
        if (orient_field == 2'b11) begin
            errors++;
            $display("FAIL R11: field=11 expected not 11");
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            errors++;
            $display("FAIL watchdog: cycles=%0d expected < 100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 0;
        step(1, 1, 2, 2, 1);                    // R9 reset dominates
        step(0, 0, 0, 0, 0);
        rst_n = 1;
        step(0, 0, 5, 5, 0);                    // R9 reset values held
        // R2 sink single Rp
        step(1, 0, 0, 4, 0);
        step(1, 0, 3, 0, 0);
        // R3 sink debug: levels and tie
        step(1, 0, 3, 5, 0);
        step(1, 0, 5, 3, 1);
        step(1, 0, 4, 4, 1);                    // tie -> CC1
        step(0, 1, 0, 0, 1);                    // R8 hold without strobe
        step(1, 0, 0, 0, 0);                    // R1 detach clears
        // R10 sink ignores Ra/Rd
        step(1, 0, 2, 1, 0);
        step(1, 0, 2, 5, 0);
        // R4 source single Rd with Ra
        step(1, 1, 1, 2, 0);
        step(1, 1, 2, 1, 0);
        step(1, 1, 2, 0, 1);
        // R5 source debug tie-break, R6 ID
        step(1, 1, 2, 2, 0);
        step(1, 1, 2, 2, 1);
        step(0, 0, 0, 0, 0);                    // R8 hold
        step(1, 0, 3, 3, 1);                    // R6 sink debug releases ID
        step(1, 1, 2, 2, 1);
        step(1, 1, 1, 1, 0);                    // R10 Ra-only is open, R1 clear
        step(1, 1, 5, 2, 0);                    // R10 source ignores Rp
        step(1, 1, 7, 6, 0);                    // R1 reserved codes
        // Random strobes with idles and role changes
        for (int i = 0; i < 3000; i++) begin
            step($urandom_range(0, 3) != 0, $urandom_range(0, 1),
                 3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)),
                 $urandom_range(0, 1));
        end
        rst_n = 0;
        step(0, 0, 0, 0, 0);                    // R9 reset mid-run
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule